// File: doc/BRIEF.md
# Wrapping Tilemap Fetch Address Generator

This block draws one scanline of a single background layer from a tilemap held in word-addressed video memory. On a line-start pulse it captures the horizontal scroll, the vertical scroll, the line number within the display frame and the map-size selection. It then runs a fixed schedule of memory reads. For every 8-pixel tile column it reads the map entry and then the two words that hold the four bit planes of the current tile row. It decodes those words into 4-bit colour indices and sends them out one pixel per clock, each with the sub-palette taken from the map entry.

The map always starts at word 0. It may be 32, 64 or 128 tiles wide and 32 or 64 tiles tall, and it wraps on both axes whatever the scroll values are. The memory behind the read port must return data one cycle after each request. Any request at or above word 0x8000 falls in unpopulated space, and the block replaces the data of that request with a fixed open-bus value. Sprites, arbitration against other memory masters and the display-window registers are handled elsewhere.

Top module: `tilemap_fetch`

## Requirements
- R1: While reset is active and after it is released, with no line start seen, rd_req and pix_valid are low.
- R2: scroll_x, scroll_y, line_num, width_sel and height_sel are sampled only on the clock edge where line_start is high. A change made later in the line has no effect on that line's pixels and is used from the next line start.
- R3: The map height is 32 tiles when height_sel is 0 and 64 tiles when it is 1. The map pixel row is y = (scroll_y + line_num) mod (8 × height). The tile row is y / 8 and the row within the tile is y mod 8.
- R4: The map width is 32 tiles when width_sel is 0, 64 when it is 1 and 128 when it is 2 or 3. Output dot d shows map column x = (scroll_x + d) mod (8 × width). The entry word address is (y / 8) × width + x / 8, counted from word 0.
- R5: In a map entry, bits 11:0 are a tile index whose tile data starts at word index × 16. Bits 15:12 are the sub-palette, driven on pix_pal for all 8 pixels of that tile.
- R6: For tile row r, one plane word is at base + r and the other at base + 8 + r. Plane 0 is in bits 7:0 of the first word, plane 1 in its bits 15:8, plane 2 in bits 7:0 of the second word and plane 3 in its bits 15:8. In each byte the most significant bit is the leftmost pixel. The pixel colour is {plane3, plane2, plane1, plane0}.
- R7: Counting clock edges after the edge that samples line_start, tile column g (g = 0 … LINE_PIXELS/8) is fetched as follows: the entry is requested in cycle 8g, nothing is requested in 8g+1, the base + r word is requested in 8g+2 and the base + 8 + r word in 8g+3. Read data is taken in the cycle after each request.
- R8: Output dot d (0 … LINE_PIXELS−1) has pix_valid high exactly in cycle 8 + (scroll_x mod 8) + d after the line-start edge, and pix_valid is low in every other cycle of the line.
- R9: Data returned for any request whose address has bit 15 set is replaced by the open-bus value 0xFFFF before use.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | One-cycle pulse that begins a scanline and captures the scroll settings |
| scroll_x | input | 10 | Horizontal scroll in pixels |
| scroll_y | input | 9 | Vertical scroll in pixels |
| line_num | input | 9 | Line index within the display frame |
| width_sel | input | 2 | Map width: 0 = 32, 1 = 64, 2 or 3 = 128 tiles |
| height_sel | input | 1 | Map height: 0 = 32, 1 = 64 tiles |
| rd_data | input | 16 | Read data, valid the cycle after rd_req |
| rd_req | output | 1 | Read request |
| rd_addr | output | 16 | Word address of the read |
| pix_valid | output | 1 | A background pixel is present |
| pix_color | output | 4 | Colour index of the pixel |
| pix_pal | output | 4 | Sub-palette of the pixel |

## Verification
On every cycle the assertions check the following: every entry request falls inside the configured map area, the second plane request sits exactly 8 words above the first, open-bus replacement follows any high-half request, at most one kind of fetch is issued per cycle, and the latched line settings hold still between line starts. Only the bench scenarios can show the decoded pixel stream itself. They cover fine-scroll alignment, wrapping on each axis for each map size, the exact cycle of every valid dot, and the fact that a scroll change made mid-line is ignored until the next line. To do this the bench compares each dot against a memory model computed from an address hash.

// File: rtl/tmf_pkg.sv
package tmf_pkg;

  localparam int ADDR_W = 16;

  typedef enum logic [1:0] {
    TAG_NONE  = 2'd0,
    TAG_ENTRY = 2'd1,
    TAG_PLO   = 2'd2,
    TAG_PHI   = 2'd3
  } rd_tag_e;

  // R4: entry address = row * width + column, map anchored at word 0.
  // Placing the column in the low bits also applies the width wrap.
  function automatic logic [ADDR_W-1:0] map_entry_addr(
    input logic [5:0] row,
    input logic [6:0] col,
    input logic [1:0] wsel
  );
    case (wsel)
      2'd0:    return {5'b0, row, col[4:0]};
      2'd1:    return {4'b0, row, col[5:0]};
      default: return {3'b0, row, col[6:0]};
    endcase
  endfunction

  // R5/R6: tile base = index * 16, word pair at +r and +8+r.
  function automatic logic [ADDR_W-1:0] tile_word_addr(
    input logic [11:0] idx,
    input logic        upper_pair,
    input logic [2:0]  trow
  );
    return {idx, upper_pair, trow};
  endfunction

  // R3: pixel row in the map, wrapped to the configured height.
  function automatic logic [8:0] map_pixel_row(
    input logic [8:0] sy,
    input logic [8:0] line,
    input logic       hsel
  );
    logic [8:0] sum;
    sum = sy + line;
    return hsel ? sum : {1'b0, sum[7:0]};
  endfunction

endpackage

// File: rtl/tmf_line_latch.sv
module tmf_line_latch
  import tmf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_start,
  input  logic [9:0] scroll_x,
  input  logic [8:0] scroll_y,
  input  logic [8:0] line_num,
  input  logic [1:0] width_sel,
  input  logic       height_sel,
  output logic [6:0] lat_col0,
  output logic [2:0] lat_fine,
  output logic [5:0] lat_row,
  output logic [2:0] lat_trow,
  output logic [1:0] lat_wsel,
  output logic       lat_hsel
);

  logic [8:0] vy;
  assign vy = map_pixel_row(scroll_y, line_num, height_sel);

  // R2: settings are captured only on the line-start edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_col0 <= '0;
      lat_fine <= '0;
      lat_row  <= '0;
      lat_trow <= '0;
      lat_wsel <= '0;
      lat_hsel <= 1'b0;
    end else if (line_start) begin
      lat_col0 <= scroll_x[9:3];
      lat_fine <= scroll_x[2:0];
      lat_row  <= vy[8:3];
      lat_trow <= vy[2:0];
      lat_wsel <= width_sel;
      lat_hsel <= height_sel;
    end
  end

endmodule

// File: rtl/tmf_fetch_seq.sv
module tmf_fetch_seq #(
  parameter int LINE_PIXELS = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_start,
  input  logic [2:0] fine,
  output logic       ev_entry_req,
  output logic       ev_plo_req,
  output logic       ev_phi_req,
  output logic       ev_load,
  output logic [6:0] group7,
  output logic       pix_valid,
  output logic       active
);

  localparam int GROUPS = LINE_PIXELS / 8;
  localparam int LAST   = 8 * (GROUPS + 2) - 1;
  localparam int CNT_W  = $clog2(LAST + 1);
  localparam int GRP_W  = CNT_W - 3;

  logic [CNT_W-1:0] cnt;
  logic [2:0]       phase;
  logic [GRP_W-1:0] group;
  logic             fetch_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (line_start) begin
      cnt    <= '0;
      active <= 1'b1;
    end else if (active) begin
      if (cnt == CNT_W'(LAST)) active <= 1'b0;
      else                     cnt    <= cnt + 1'b1;
    end
  end

  assign phase    = cnt[2:0];
  assign group    = cnt[CNT_W-1:3];
  assign group7   = 7'(group);
  assign fetch_ok = active && (32'(group) <= 32'(GROUPS));

  // R7: entry at phase 0, plane words at phases 2 and 3.
  assign ev_entry_req = fetch_ok && (phase == 3'd0);
  assign ev_plo_req   = fetch_ok && (phase == 3'd2);
  assign ev_phi_req   = fetch_ok && (phase == 3'd3);
  assign ev_load      = fetch_ok && (phase == 3'd7);

  // R8: dot d appears 8 + fine + d cycles after the line start.
  assign pix_valid = active
                  && (32'(cnt) >= 32'd8 + 32'(fine))
                  && (32'(cnt) <  32'(8 + LINE_PIXELS) + 32'(fine));

endmodule

// File: rtl/tmf_pixel_shifter.sv
module tmf_pixel_shifter (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [15:0] w_lo,
  input  logic [15:0] w_hi,
  input  logic [3:0]  pal_in,
  output logic [3:0]  color,
  output logic [3:0]  pal
);

  // R6: four plane bytes, leftmost pixel in the MSB.
  for (genvar pl = 0; pl < 4; pl++) begin : g_plane
    logic [15:0] src;
    logic [7:0]  sh;
    assign src = (pl < 2) ? w_lo : w_hi;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sh <= '0;
      else if (load) sh <= src[8*(pl%2) +: 8];
      else           sh <= {sh[6:0], 1'b0};
    end
    assign color[pl] = sh[7];
  end

  // R5: sub-palette follows the tile it came from.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pal <= '0;
    else if (load) pal <= pal_in;
  end

endmodule

// File: rtl/tilemap_fetch.sv
module tilemap_fetch
  import tmf_pkg::*;
#(
  parameter int          LINE_PIXELS = 256,
  parameter logic [15:0] OPEN_BUS    = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        line_start,
  input  logic [9:0]  scroll_x,
  input  logic [8:0]  scroll_y,
  input  logic [8:0]  line_num,
  input  logic [1:0]  width_sel,
  input  logic        height_sel,
  input  logic [15:0] rd_data,
  output logic        rd_req,
  output logic [15:0] rd_addr,
  output logic        pix_valid,
  output logic [3:0]  pix_color,
  output logic [3:0]  pix_pal
);

  logic [6:0]  lat_col0;
  logic [2:0]  lat_fine, lat_trow;
  logic [5:0]  lat_row;
  logic [1:0]  lat_wsel;
  logic        lat_hsel;

  logic        ev_entry_req, ev_plo_req, ev_phi_req, ev_load, active;
  logic [6:0]  group7;
  logic [6:0]  col;

  rd_tag_e     tag_q;
  logic        hi_q;
  logic [15:0] eff_data;
  logic [15:0] entry_q, wlo_q, whi_q;

  tmf_line_latch u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .scroll_x   (scroll_x),
    .scroll_y   (scroll_y),
    .line_num   (line_num),
    .width_sel  (width_sel),
    .height_sel (height_sel),
    .lat_col0   (lat_col0),
    .lat_fine   (lat_fine),
    .lat_row    (lat_row),
    .lat_trow   (lat_trow),
    .lat_wsel   (lat_wsel),
    .lat_hsel   (lat_hsel)
  );

  tmf_fetch_seq #(.LINE_PIXELS(LINE_PIXELS)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_start   (line_start),
    .fine         (lat_fine),
    .ev_entry_req (ev_entry_req),
    .ev_plo_req   (ev_plo_req),
    .ev_phi_req   (ev_phi_req),
    .ev_load      (ev_load),
    .group7       (group7),
    .pix_valid    (pix_valid),
    .active       (active)
  );

  // R4: column wraps because the address function keeps only width bits.
  assign col    = lat_col0 + group7;
  assign rd_req = ev_entry_req | ev_plo_req | ev_phi_req;

  always_comb begin
    rd_addr = '0;
    if (ev_entry_req)    rd_addr = map_entry_addr(lat_row, col, lat_wsel);
    else if (ev_plo_req) rd_addr = tile_word_addr(entry_q[11:0], 1'b0, lat_trow);
    else if (ev_phi_req) rd_addr = tile_word_addr(entry_q[11:0], 1'b1, lat_trow);
  end

  // R9: unpopulated upper half reads as the open-bus constant.
  assign eff_data = hi_q ? OPEN_BUS : rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q   <= TAG_NONE;
      hi_q    <= 1'b0;
      entry_q <= '0;
      wlo_q   <= '0;
      whi_q   <= '0;
    end else begin
      hi_q  <= rd_req && rd_addr[15];
      tag_q <= ev_entry_req ? TAG_ENTRY :
               ev_plo_req   ? TAG_PLO   :
               ev_phi_req   ? TAG_PHI   : TAG_NONE;
      // R7: data is taken the cycle after its request.
      case (tag_q)
        TAG_ENTRY: entry_q <= eff_data;
        TAG_PLO:   wlo_q   <= eff_data;
        TAG_PHI:   whi_q   <= eff_data;
        default:   ;
      endcase
    end
  end

  tmf_pixel_shifter u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (ev_load),
    .w_lo   (wlo_q),
    .w_hi   (whi_q),
    .pal_in (entry_q[15:12]),
    .color  (pix_color),
    .pal    (pix_pal)
  );

endmodule

// File: rtl/tmf_checks.sv
module tmf_checks #(
  parameter logic [15:0] OPEN_BUS = 16'hFFFF
) (
  input logic        clk,
  input logic        rst_n,
  input logic        line_start,
  input logic        rd_req,
  input logic [15:0] rd_addr,
  input logic [15:0] eff_data,
  input logic        ev_entry_req,
  input logic        ev_plo_req,
  input logic        ev_phi_req,
  input logic [1:0]  lat_wsel,
  input logic        lat_hsel,
  input logic [18:0] lat_state,
  input logic        pix_valid,
  input logic        active
);

  logic [16:0] map_words;
  always_comb begin
    map_words = 17'd1 << ((lat_wsel == 2'd0 ? 5 : lat_wsel == 2'd1 ? 6 : 7)
                          + (lat_hsel ? 6 : 5));
  end

  // R4
  entry_in_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_entry_req |-> ({1'b0, rd_addr} < map_words));

  // R6
  pair_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_phi_req |-> (rd_addr == $past(rd_addr) + 16'd8));

  // R9
  open_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_req && rd_addr[15]) |-> (eff_data == OPEN_BUS));

  // R7
  one_fetch_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_entry_req, ev_plo_req, ev_phi_req}));

  // R2
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> $stable(lat_state));

  // R8
  valid_in_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> active);

endmodule

bind tilemap_fetch tmf_checks #(.OPEN_BUS(OPEN_BUS)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .line_start   (line_start),
  .rd_req       (rd_req),
  .rd_addr      (rd_addr),
  .eff_data     (eff_data),
  .ev_entry_req (ev_entry_req),
  .ev_plo_req   (ev_plo_req),
  .ev_phi_req   (ev_phi_req),
  .lat_wsel     (lat_wsel),
  .lat_hsel     (lat_hsel),
  .lat_state    ({lat_col0, lat_fine, lat_row, lat_trow}),
  .pix_valid    (pix_valid),
  .active       (active)
);

// File: tb/tilemap_fetch_tb_top.sv
module tilemap_fetch_tb_top;

  localparam int LP   = 256;
  localparam int LAST = 8 * (LP / 8 + 2) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_start = 1'b0;
  logic [9:0]  scroll_x = '0;
  logic [8:0]  scroll_y = '0;
  logic [8:0]  line_num = '0;
  logic [1:0]  width_sel = '0;
  logic        height_sel = 1'b0;
  logic [15:0] rd_data = '0;
  logic        rd_req;
  logic [15:0] rd_addr;
  logic        pix_valid;
  logic [3:0]  pix_color, pix_pal;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  force_hi = 1'b0;

  always #10 clk = ~clk;

  tilemap_fetch #(.LINE_PIXELS(LP)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_start(line_start),
    .scroll_x(scroll_x), .scroll_y(scroll_y), .line_num(line_num),
    .width_sel(width_sel), .height_sel(height_sel), .rd_data(rd_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .pix_valid(pix_valid),
    .pix_color(pix_color), .pix_pal(pix_pal)
  );

  // Memory content is a hash of the address; map entries steer bit 11.
  function automatic logic [15:0] vram(input int a);
    logic [31:0] h;
    logic [15:0] w;
    h = 32'(a) * 32'h9E3779B1;
    w = h[31:16] ^ 16'(a);
    if (a < 8192) w[11] = force_hi;
    return w;
  endfunction

  function automatic logic [15:0] mem_rd(input int a);
    if (a >= 32768) return 16'hFFFF;
    return vram(a);
  endfunction

  always @(posedge clk) rd_data <= rd_req ? vram(int'(rd_addr)) : 16'h0;

  function automatic int wtiles(input int ws);
    return (ws == 0) ? 32 : (ws == 1) ? 64 : 128;
  endfunction

  function automatic int entry_addr(input int sx, sy, ln, ws, hs, d);
    int wt, ht, x, y;
    wt = wtiles(ws);
    ht = hs ? 64 : 32;
    x = (sx + d) % (wt * 8);
    y = (sy + ln) % (ht * 8);
    return (y / 8) * wt + x / 8;
  endfunction

  function automatic logic [7:0] exp_pix(input int sx, sy, ln, ws, hs, d);
    int wt, ht, x, y, base, k;
    logic [15:0] ent, a, b;
    wt = wtiles(ws);
    ht = hs ? 64 : 32;
    x = (sx + d) % (wt * 8);
    y = (sy + ln) % (ht * 8);
    ent = mem_rd(entry_addr(sx, sy, ln, ws, hs, d));
    base = int'(ent[11:0]) * 16;
    a = mem_rd(base + y % 8);
    b = mem_rd(base + 8 + y % 8);
    k = x % 8;
    return {ent[15:12], b[15-k], b[7-k], a[15-k], a[7-k]};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One scanline; every cycle checks valid timing and pixel contents.
  task automatic run_line(input int sx, sy, ln, ws, hs, input string req,
                          input bit fetch_chk, input int new_sx);
    int fine, d, ea, tb;
    logic [15:0] ent;
    @(negedge clk);
    scroll_x = 10'(sx); scroll_y = 9'(sy); line_num = 9'(ln);
    width_sel = 2'(ws); height_sel = hs[0]; line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    fine = sx % 8;
    ea  = entry_addr(sx, sy, ln, ws, hs, 0);
    ent = mem_rd(ea);
    tb  = int'(ent[11:0]) * 16 + ((sy + ln) % 8);
    for (int t = 0; t < LAST + 3; t++) begin
      bit ev;
      if (t > 0) @(negedge clk);
      if (t == 40 && new_sx >= 0) scroll_x = 10'(new_sx);
      if (fetch_chk) begin
        // R7: fetch order of the first tile column
        if (t == 0) check(rd_req && rd_addr == 16'(ea), "R7 entry fetch", int'(rd_addr), ea);
        if (t == 1) check(!rd_req, "R7 idle slot", int'(rd_req), 0);
        if (t == 2) check(rd_req && rd_addr == 16'(tb), "R7 low pair fetch", int'(rd_addr), tb);
        if (t == 3) check(rd_req && rd_addr == 16'(tb + 8), "R7 high pair fetch", int'(rd_addr), tb + 8);
      end
      ev = (t >= 8 + fine) && (t < 8 + fine + LP);
      check(pix_valid == ev, {req, " R8 valid timing"}, int'(pix_valid), int'(ev));
      if (ev && pix_valid) begin
        logic [7:0] e;
        d = t - 8 - fine;
        e = exp_pix(sx, sy, ln, ws, hs, d);
        check({pix_pal, pix_color} == e, {req, " pixel"}, int'({pix_pal, pix_color}), int'(e));
      end
    end
  endtask

  task automatic t_reset;
    check(!rd_req && !pix_valid, "R1 in reset", int'({rd_req, pix_valid}), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!rd_req && !pix_valid, "R1 idle after reset", int'({rd_req, pix_valid}), 0);
  endtask

  task automatic t_plain;    run_line(0, 0, 0, 0, 0, "R5 R6 plain", 1'b1, -1); endtask
  task automatic t_fine;     run_line(13, 5, 20, 1, 0, "R4 R8 fine scroll", 1'b1, -1); endtask
  task automatic t_wrap_x;   run_line(1000, 0, 3, 0, 0, "R4 wrap 32 wide", 1'b0, -1); endtask
  task automatic t_wrap_128; run_line(1004, 500, 30, 2, 1, "R3 R4 wrap 128x64", 1'b1, -1); endtask
  task automatic t_wrap_y32; run_line(77, 250, 9, 3, 0, "R3 wrap 32 tall", 1'b0, -1); endtask

  task automatic t_midline;
    run_line(21, 40, 7, 1, 1, "R2 mid-line change ignored", 1'b0, 300);
    run_line(300, 40, 8, 1, 1, "R2 next line uses new", 1'b0, -1);
  endtask

  task automatic t_open_bus;
    force_hi = 1'b1;
    run_line(6, 17, 2, 0, 1, "R9 open bus", 1'b1, -1);
    force_hi = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_plain();
    t_fine();
    t_wrap_x();
    t_wrap_128();
    t_wrap_y32();
    t_midline();
    t_open_bus();
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule